// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block keeps the internal array address of a synchronous burst memory. A full address is captured from the external address bus whenever one of two active-low address strobes is asserted. One strobe, intended for a cache controller, loads unconditionally. The other, intended for a processor, loads only while the active-low chip enable is asserted.

After a load, a 2-bit beat counter starts at zero. It advances on each rising edge where the active-low advance input is asserted, so one presented address yields four beats. Only the two lowest address bits take part in the burst. A static order-select input chooses between two orderings of those bits relative to the starting address: linear (wrapping add) or interleaved (XOR). The upper address bits pass through unchanged from the captured address.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_ni` is low, and on the first sample after its release, `array_addr_o` and `beat_o` are both zero.
- R2: A rising edge with `ads_ctrl_ni` low loads `addr_i` into the address register, whatever the values of `ce_ni` and `adv_ni`. After that edge `beat_o` is 0 and `array_addr_o` equals the loaded address.
- R3: A rising edge with `ads_proc_ni` low and `ce_ni` low loads the address in the same way as R2.
- R4: With `ce_ni` high, a low `ads_proc_ni` has no effect. The block behaves as if that strobe were high, so the stored address is kept and `adv_ni` alone decides the beat.
- R5: On a rising edge with no load and `adv_ni` low, `beat_o` increments by one modulo 4. After beat 3 it returns to 0, and the same four addresses repeat.
- R6: On a rising edge with no load and `adv_ni` high, `beat_o` and `array_addr_o` keep their values.
- R7: With `order_sel_i` low (linear), `array_addr_o[1:0]` equals the loaded bits [1:0] plus `beat_o`, modulo 4.
- R8: With `order_sel_i` high (interleaved), `array_addr_o[1:0]` equals the loaded bits [1:0] XOR `beat_o`.
- R9: `array_addr_o[AW-1:2]` equals bits [AW-1:2] of the last loaded address on every beat of a burst.
- R10: When a load strobe and `adv_ni` are both active on the same edge, the load wins and `beat_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External address bus |
| ads_proc_ni | input | 1 | Processor address strobe, active low, gated by chip enable |
| ads_ctrl_ni | input | 1 | Controller address strobe, active low |
| ce_ni | input | 1 | Chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| array_addr_o | output | AW | Internal array address |
| beat_o | output | 2 | Current beat index within the burst |

## Verification
The assertions assume that `order_sel_i` is static while the block runs. Both the hold check and the per-beat address relations would fail if the order changed in the middle of a burst. The bench therefore changes `order_sel_i` only while `rst_ni` is held low, and runs each order as its own phase. Inside a phase, the strobes, chip enable, advance and address are driven freely, including the cases where both strobes are low, where the gated strobe is low with chip enable high, and where a strobe and advance are low together.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode (
  input  logic ads_proc_ni,
  input  logic ads_ctrl_ni,
  input  logic ce_ni,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_load;
  logic ctrl_load;

  // processor strobe only counts when the chip is enabled
  assign proc_load = ~ads_proc_ni & ~ce_ni;
  assign ctrl_load = ~ads_ctrl_ni;
  assign load_o    = proc_load | ctrl_load;
  // a load overrides advance
  assign step_o    = ~adv_ni & ~load_o;
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_addr_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output beat_t beat_o
);
  beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_q + beat_t'(1);
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_seq_pkg::*;
(
  input  beat_t  start_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  low_o
);
  beat_t lin_low;
  beat_t ilv_low;

  assign lin_low = start_i + beat_i;
  assign ilv_low = start_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      ORDER_INTERLEAVED: low_o = ilv_low;
      default:           low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_seq_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ads_proc_ni,
  input  logic          ads_ctrl_ni,
  input  logic          ce_ni,
  input  logic          adv_ni,
  input  logic          order_sel_i,
  output logic [AW-1:0] array_addr_o,
  output logic [1:0]    beat_o
);
  localparam int unsigned UPPER_W = AW - BEAT_W;

  logic          load;
  logic          step;
  beat_t         beat;
  beat_t         low_bits;
  logic [AW-1:0] base_addr;
  order_e        order;

  assign order = order_e'(order_sel_i);

  burst_strobe_decode u_decode (
    .ads_proc_ni (ads_proc_ni),
    .ads_ctrl_ni (ads_ctrl_ni),
    .ce_ni       (ce_ni),
    .adv_ni      (adv_ni),
    .load_o      (load),
    .step_o      (step)
  );

  burst_addr_reg #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .addr_o (base_addr)
  );

  burst_beat_counter u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .beat_o (beat)
  );

  burst_order_map u_map (
    .start_i (base_addr[BEAT_W-1:0]),
    .beat_i  (beat),
    .order_i (order),
    .low_o   (low_bits)
  );

  assign array_addr_o = {base_addr[AW-1:BEAT_W], low_bits};
  assign beat_o       = beat;

  logic [UPPER_W-1:0] unused_upper;
  assign unused_upper = '0;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned AW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          ads_proc_ni,
  input logic          ads_ctrl_ni,
  input logic          ce_ni,
  input logic          adv_ni,
  input logic          order_sel_i,
  input logic [AW-1:0] array_addr_o,
  input logic [1:0]    beat_o
);
  logic strobe;
  assign strobe = !ads_ctrl_ni || (!ads_proc_ni && !ce_ni);

  assert_ctrl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_ctrl_ni |=> beat_o == 2'd0);

  assert_proc_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_ni && !ce_ni) |=> array_addr_o == $past(addr_i));

  assert_gated_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !ads_proc_ni && ads_ctrl_ni) |=>
      array_addr_o[AW-1:2] == $past(array_addr_o[AW-1:2]));

  assert_advance_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !adv_ni) |=> beat_o == $past(beat_o) + 2'd1);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && adv_ni) |=> $stable(beat_o) && $stable(array_addr_o));

  assert_first_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> array_addr_o[1:0] == $past(addr_i[1:0]));

  assert_upper_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(array_addr_o[AW-1:2]));

  assert_load_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !adv_ni) |=> beat_o == 2'd0);

  assert_order_static_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(order_sel_i) || $past(!rst_ni));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 17;
  localparam int MAX_CYCLES = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ads_proc_ni = 1'b1;
  logic          ads_ctrl_ni = 1'b1;
  logic          ce_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          order_sel_i = 1'b0;
  logic [AW-1:0] array_addr_o;
  logic [1:0]    beat_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int    m_base = 0;
  int    m_beat = 0;
  string m_tag  = "R1";

  always #2.5 clk_i = ~clk_i;

  burst_addr_seq #(.AW(AW)) dut_i (.*);

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int exp_addr();
    int lo;
    if (order_sel_i) lo = (m_base & 3) ^ m_beat;
    else             lo = ((m_base & 3) + m_beat) & 3;
    return (m_base & ~3) | lo;
  endfunction

  task automatic compare();
    check(m_tag, int'(beat_o), m_beat);
    check(order_sel_i ? "R8" : "R7", int'(array_addr_o[1:0]), exp_addr() & 3);
    check("R9", int'(array_addr_o) >> 2, m_base >> 2);
  endtask

  // one cycle: drive, clock, update model, sample at falling edge
  task automatic cycle(int a, bit pn, bit cn, bit ce, bit adv);
    bit ld;
    addr_i = AW'(a); ads_proc_ni = pn; ads_ctrl_ni = cn; ce_ni = ce; adv_ni = adv;
    @(posedge clk_i);
    ld = !cn || (!pn && !ce);
    if (ld) begin
      m_base = a & ((1 << AW) - 1);
      m_beat = 0;
      m_tag = !adv ? "R10" : (!cn ? "R2" : "R3");
    end else if (!adv) begin
      m_beat = (m_beat + 1) & 3;
      m_tag = (!pn && ce) ? "R4" : "R5";
    end else begin
      m_tag = (!pn && ce) ? "R4" : "R6";
    end
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_reset(bit ord);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_base = 0; m_beat = 0; m_tag = "R1";
    #1;
    check("R1", int'(beat_o), 0);
    check("R1", int'(array_addr_o), 0);
    order_sel_i = ord;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", int'(array_addr_o), 0);
  endtask

  task automatic phase(bit ord);
    do_reset(ord);
    // controller strobe, then full burst with wrap
    cycle('h1_2345, 1, 0, 1, 1);
    for (int i = 0; i < 6; i++) cycle('h0_0000, 1, 1, 0, 0);
    // hold
    for (int i = 0; i < 3; i++) cycle('h1_FFFF, 1, 1, 0, 1);
    // processor strobe gated by chip enable high
    cycle('h0_ABCE, 0, 1, 1, 1);
    cycle('h0_ABCF, 0, 1, 1, 0);
    // processor strobe with chip enable
    cycle('h0_7772, 0, 1, 0, 1);
    for (int i = 0; i < 4; i++) cycle('h0_0000, 1, 1, 1, 0);
    // load together with advance
    cycle('h1_0003, 0, 1, 0, 0);
    cycle('h0_5551, 1, 0, 1, 0);
    cycle('h0_0000, 1, 1, 1, 0);
    // random traffic, every start offset
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      cycle(int'($urandom) & ((1 << AW) - 1), r[0] | r[1], r[2] | r[3] | r[4],
            r[5], r[6] & r[7]);
    end
  endtask

  initial begin
    phase(1'b0);
    phase(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, MAX_CYCLES);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule